// File: doc/BRIEF.md
# Two-Frame Diagonal Bit Interleaver for Coded Speech

This block spreads each 456-bit coded speech frame over eight radio bursts so that a burst lost to fading damages only a small, scattered part of any one frame. Coded bits arrive one per accepted cycle on a serial input. A strobe marks the first bit of a frame. A frame is cut into eight 57-bit groups: frame bit k goes to group k mod 8, at slot k div 8 of that group.

Each completed frame releases four 114-bit burst payloads on four consecutive cycles. Burst b (b = 0..3) interleaves two groups. Group b of the frame that has just completed fills the even payload positions. Group b+4 of the frame before it fills the odd positions. Groups 4..7 of a frame therefore appear in the bursts released by the next frame. Every coded bit leaves the block exactly once, and the bit rate is unchanged. Two frame banks alternate between writing and reading, and a holding register keeps the upper half of the previous frame.

Top module: `gsm_interleaver`

## Requirements
- R1: While reset is high and after it is released, `burst_valid` is low until a frame completes.
- R2: The cycle after the 456th accepted bit of a frame, `burst_valid` goes high for exactly four consecutive cycles. `burst_idx` reads 0, 1, 2, 3 in turn, and `burst_valid` is low in the following cycle.
- R3: In burst b, payload position 2p (bit 2p of `burst_data`, p = 0..56) equals bit 8p+b of the frame that has just completed.
- R4: In burst b, payload position 2p+1 equals bit 8p+b+4 of the previously completed frame.
- R5: For the first frame completed after reset, every odd payload position is 0.
- R6: An accepted bit with `frame_start` high is bit 0 of a new frame. Any partial frame is discarded and produces no bursts. After bit 455, the next accepted bit is bit 0 of the next frame even without `frame_start`.
- R7: Cycles with `bit_valid` low are ignored, whatever `bit_in` and `frame_start` hold.
- R8: After reset, accepted bits are ignored until the first `bit_valid` cycle with `frame_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial coded bit |
| bit_valid | input | 1 | `bit_in` carries a bit this cycle |
| frame_start | input | 1 | This bit is bit 0 of a frame (used only with `bit_valid`) |
| burst_data | output | 114 | Interleaved burst payload |
| burst_valid | output | 1 | `burst_data` holds a burst |
| burst_idx | output | 2 | Burst number 0..3 within the current release |

## Verification
The hardest case to reach is a frame boundary that does not line up with the count of 456 bits. Examples are a restart strobe in the middle of a frame, or bits that arrive before any strobe. Either one could leave stale groups in the banks or the holding register that only show up one frame later in the odd positions. The stimulus aborts a frame after 200 bits and then sends a full frame. It also resets in the middle of a run and feeds 500 unframed bits before the next strobe. In both cases it checks that the odd positions carry the last complete frame, or zeros after reset. Idle cycles carrying inverted data and a stray strobe are mixed into one frame.

// File: rtl/gsm_il_pkg.sv
package gsm_il_pkg;
    localparam int IL_GROUPS     = 8;
    localparam int IL_GROUP_BITS = 57;
    localparam int IL_FRAME_BITS = IL_GROUPS * IL_GROUP_BITS;

    typedef enum logic {
        SYNC_SEARCH = 1'b0,
        SYNC_LOCKED = 1'b1
    } sync_e;

    function automatic int half_of(input int groups);
        return groups / 2;
    endfunction
endpackage

// File: rtl/gsm_il_framer.sv
module gsm_il_framer
    import gsm_il_pkg::*;
#(
    parameter  int FRAME_BITS = IL_FRAME_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             frame_start,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_addr,
    output logic             frame_done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    sync_e            state;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_en      = bit_valid && (frame_start || state == SYNC_LOCKED);
        wr_addr    = frame_start ? '0 : cnt;
        frame_done = wr_en && (wr_addr == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SYNC_SEARCH;
            cnt   <= '0;
        end else if (wr_en) begin
            state <= SYNC_LOCKED;
            cnt   <= frame_done ? '0 : wr_addr + 1'b1;
        end
    end
endmodule

// File: rtl/gsm_il_store.sv
module gsm_il_store
    import gsm_il_pkg::*;
#(
    parameter  int GROUPS     = IL_GROUPS,
    parameter  int GROUP_BITS = IL_GROUP_BITS,
    localparam int FRAME_BITS = GROUPS * GROUP_BITS,
    localparam int HALF       = half_of(GROUPS),
    localparam int HOLD_BITS  = HALF * GROUP_BITS,
    localparam int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CNT_W-1:0]      wr_addr,
    input  logic                  wr_bit,
    input  logic                  frame_done,
    input  logic                  hold_load,
    output logic [FRAME_BITS-1:0] rd_frame,
    output logic [HOLD_BITS-1:0]  hold
);
    logic [FRAME_BITS-1:0] bank [2];
    logic                  wsel;
    logic                  rsel;
    logic [HOLD_BITS-1:0]  upper;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            bank[wsel][wr_addr] <= wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wsel <= 1'b0;
            rsel <= 1'b0;
            hold <= '0;
        end else begin
            if (frame_done) begin
                rsel <= wsel;
                wsel <= ~wsel;
            end
            if (hold_load) begin
                hold <= upper;
            end
        end
    end

    assign rd_frame = bank[rsel];

    for (genvar p = 0; p < GROUP_BITS; p++) begin : g_slot
        for (genvar h = 0; h < HALF; h++) begin : g_grp
            assign upper[p*HALF + h] = rd_frame[p*GROUPS + HALF + h];
        end
    end
endmodule

// File: rtl/gsm_il_sequencer.sv
module gsm_il_sequencer #(
    parameter  int HALF  = 4,
    localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_done,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             hold_load
);
    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } seq_t;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(HALF - 1);

    seq_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (frame_done) begin
            st <= '{active: 1'b1, idx: '0};
        end else if (st.active) begin
            if (st.idx == LAST) st <= '0;
            else                st.idx <= st.idx + 1'b1;
        end
    end

    assign active    = st.active;
    assign idx       = st.idx;
    assign hold_load = st.active && (st.idx == LAST);
endmodule

// File: rtl/gsm_il_payload_mux.sv
module gsm_il_payload_mux
    import gsm_il_pkg::*;
#(
    parameter  int GROUPS     = IL_GROUPS,
    parameter  int GROUP_BITS = IL_GROUP_BITS,
    localparam int FRAME_BITS = GROUPS * GROUP_BITS,
    localparam int HALF       = half_of(GROUPS),
    localparam int HOLD_BITS  = HALF * GROUP_BITS,
    localparam int IDX_W      = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic [FRAME_BITS-1:0]   rd_frame,
    input  logic [HOLD_BITS-1:0]    hold,
    input  logic [IDX_W-1:0]        idx,
    output logic [2*GROUP_BITS-1:0] payload
);
    for (genvar p = 0; p < GROUP_BITS; p++) begin : g_pair
        assign payload[2*p]     = rd_frame[p*GROUPS + int'(idx)];
        assign payload[2*p + 1] = hold[p*HALF + int'(idx)];
    end
endmodule

// File: rtl/gsm_interleaver.sv
module gsm_interleaver
    import gsm_il_pkg::*;
#(
    parameter int GROUPS     = IL_GROUPS,
    parameter int GROUP_BITS = IL_GROUP_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bit_in,
    input  logic                          bit_valid,
    input  logic                          frame_start,
    output logic [2*GROUP_BITS-1:0]       burst_data,
    output logic                          burst_valid,
    output logic [$clog2(GROUPS/2)-1:0]   burst_idx
);
    localparam int FRAME_BITS = GROUPS * GROUP_BITS;
    localparam int HALF       = half_of(GROUPS);
    localparam int HOLD_BITS  = HALF * GROUP_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    logic                  wr_en;
    logic [CNT_W-1:0]      wr_addr;
    logic                  frame_done;
    logic                  hold_load;
    logic [FRAME_BITS-1:0] rd_frame;
    logic [HOLD_BITS-1:0]  hold;

    gsm_il_framer #(.FRAME_BITS(FRAME_BITS)) i_framer (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .frame_start(frame_start),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .frame_done (frame_done)
    );

    gsm_il_store #(.GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS)) i_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_bit    (bit_in),
        .frame_done(frame_done),
        .hold_load (hold_load),
        .rd_frame  (rd_frame),
        .hold      (hold)
    );

    gsm_il_sequencer #(.HALF(HALF)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .frame_done(frame_done),
        .active    (burst_valid),
        .idx       (burst_idx),
        .hold_load (hold_load)
    );

    gsm_il_payload_mux #(.GROUPS(GROUPS), .GROUP_BITS(GROUP_BITS)) i_mux (
        .rd_frame(rd_frame),
        .hold    (hold),
        .idx     (burst_idx),
        .payload (burst_data)
    );
endmodule

// File: rtl/gsm_il_checker.sv
module gsm_il_checker #(
    parameter  int FRAME_BITS = 456,
    parameter  int HALF       = 4,
    localparam int IDX_W      = $clog2(HALF),
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_valid,
    input logic             frame_start,
    input logic             burst_valid,
    input logic [IDX_W-1:0] burst_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);

    logic             ck_lock;
    logic [CNT_W-1:0] ck_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_lock <= 1'b0;
            ck_cnt  <= '0;
        end else if (bit_valid && frame_start) begin
            ck_lock <= 1'b1;
            ck_cnt  <= CNT_W'(1);
        end else if (bit_valid && ck_lock) begin
            ck_cnt  <= (ck_cnt == FULL) ? CNT_W'(1) : ck_cnt + 1'b1;
        end
    end

    AST_BURST_FIRST_IDX: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_valid) |-> burst_idx == '0);  // R2

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && burst_idx != LAST_IDX) |=>
            (burst_valid && burst_idx == IDX_W'($past(burst_idx) + 1'b1)));  // R2

    AST_BURST_END: assert property (@(posedge clk) disable iff (rst)
        (burst_valid && burst_idx == LAST_IDX) |=> !burst_valid);  // R2

    AST_FULL_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_valid) |-> (ck_lock && ck_cnt == FULL));  // R6

    AST_NO_BURST_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !ck_lock |-> !burst_valid);  // R8
endmodule

bind gsm_interleaver gsm_il_checker #(
    .FRAME_BITS(GROUPS * GROUP_BITS),
    .HALF      (GROUPS / 2)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .frame_start(frame_start),
    .burst_valid(burst_valid),
    .burst_idx  (burst_idx)
);

// File: tb/test_gsm_interleaver.sv
module test_gsm_interleaver;
    logic         clk = 1'b0;
    logic         rst;
    logic         bit_in;
    logic         bit_valid;
    logic         frame_start;
    logic [113:0] burst_data;
    logic         burst_valid;
    logic [1:0]   burst_idx;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int seen   = 0;
    logic [455:0] last_f;

    always #4 clk = ~clk;

    gsm_interleaver i_gsm_interleaver (
        .clk        (clk),
        .rst        (rst),
        .bit_in     (bit_in),
        .bit_valid  (bit_valid),
        .frame_start(frame_start),
        .burst_data (burst_data),
        .burst_valid(burst_valid),
        .burst_idx  (burst_idx)
    );

    always @(negedge clk) if (burst_valid === 1'b1) seen++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most 200000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [113:0] act, input logic [113:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [455:0] make_frame(input int seed);
        logic [455:0] f;
        for (int k = 0; k < 456; k++) begin
            logic [31:0] v;
            v = 32'(k + 1) * 32'(2 * seed + 1) * 32'h9E3779B1;
            f[k] = v[17] ^ v[29];
        end
        return f;
    endfunction

    task automatic push(input logic b, input logic s);
        @(negedge clk);
        bit_in = b; bit_valid = 1'b1; frame_start = s;
        @(posedge clk);
    endtask

    task automatic idle(input logic b, input logic s);
        @(negedge clk);
        bit_in = b; bit_valid = 1'b0; frame_start = s;
        @(posedge clk);
    endtask

    task automatic send_frame(input logic [455:0] f, input bit use_start, input int gap);
        for (int k = 0; k < 456; k++) begin
            if (gap > 0 && (k % gap) == gap - 1) idle(~f[k], 1'b1);
            push(f[k], use_start && k == 0);
        end
    endtask

    task automatic expect_bursts(input logic [455:0] cur, input logic [455:0] prev,
                                 input string req_odd);
        for (int b = 0; b < 4; b++) begin
            logic [113:0] exp;
            logic [113:0] ev_m;
            @(negedge clk);
            bit_valid = 1'b0; frame_start = 1'b0;
            for (int p = 0; p < 57; p++) begin
                exp[2*p]     = cur[8*p + b];
                exp[2*p + 1] = prev[8*p + b + 4];
                ev_m[2*p]    = 1'b1;
                ev_m[2*p + 1]= 1'b0;
            end
            check(burst_valid === 1'b1 && burst_idx === 2'(b), "R2", "valid/idx",
                  {111'd0, burst_valid, burst_idx}, {111'd0, 1'b1, 2'(b)});
            check((burst_data & ev_m) === (exp & ev_m), "R3", "even positions",
                  burst_data & ev_m, exp & ev_m);
            check((burst_data & ~ev_m) === (exp & ~ev_m), req_odd, "odd positions",
                  burst_data & ~ev_m, exp & ~ev_m);
        end
        @(negedge clk);
        check(burst_valid === 1'b0, "R2", "valid after fourth burst",
              {113'd0, burst_valid}, 114'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; bit_in = 1'b0; bit_valid = 1'b0; frame_start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(burst_valid === 1'b0, "R1", "valid in reset", {113'd0, burst_valid}, 114'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(burst_valid === 1'b0, "R1", "valid after reset", {113'd0, burst_valid}, 114'd0);
    endtask

    task automatic t_first_frame();
        logic [455:0] f = make_frame(1);
        send_frame(f, 1'b1, 0);
        expect_bursts(f, '0, "R5");
        last_f = f;
    endtask

    task automatic t_chained(input int seed, input bit use_start);
        logic [455:0] f = make_frame(seed);
        send_frame(f, use_start, 0);
        expect_bursts(f, last_f, use_start ? "R4" : "R6");
        last_f = f;
    endtask

    task automatic t_gaps();
        logic [455:0] f = make_frame(4);
        send_frame(f, 1'b1, 3);
        expect_bursts(f, last_f, "R7");
        last_f = f;
    endtask

    task automatic t_restart();
        logic [455:0] junk = make_frame(9);
        logic [455:0] f    = make_frame(5);
        int s0 = seen;
        for (int k = 0; k < 200; k++) push(junk[k], k == 0);
        check(seen == s0, "R6", "bursts from partial frame", 114'(seen - s0), 114'd0);
        send_frame(f, 1'b1, 0);
        expect_bursts(f, last_f, "R6");
        last_f = f;
    endtask

    task automatic t_unlocked();
        logic [455:0] junk = make_frame(11);
        logic [455:0] f    = make_frame(6);
        int s0;
        @(negedge clk);
        rst = 1'b1; bit_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        s0 = seen;
        for (int k = 0; k < 500; k++) push(junk[k % 456], 1'b0);
        @(negedge clk);
        bit_valid = 1'b0;
        check(seen == s0, "R8", "bursts before first strobe", 114'(seen - s0), 114'd0);
        send_frame(f, 1'b1, 0);
        expect_bursts(f, '0, "R5");
        last_f = f;
    endtask

    initial begin
        last_f = '0;
        t_reset();
        t_first_frame();
        t_chained(2, 1'b1);
        t_chained(3, 1'b0);
        t_gaps();
        t_restart();
        t_unlocked();
        t_chained(7, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule